// File: doc/BRIEF.md
# Per-Area Bus Wait-State Inserter

This block stretches external bus accesses by a programmable number of wait cycles. Each of eight address areas owns a 2-bit wait field. The fields are packed into two 8-bit control registers, which software can write and read back. When a bus cycle starts, the block looks up the field for the area being accessed and loads a down-counter. It then holds `wait_o` high for that many cycles and raises `ready_o` for a single cycle.

Waits are added only for external accesses to areas whose three-state-access enable bit is set. Accesses to on-chip memory or internal registers finish with no added cycles. Power-on reset and hardware standby force both registers to all ones, so every area defaults to three waits. A manual reset or software standby stops the access in progress but leaves the register contents untouched. Area decoding, the bus-cycle sequencer and the external wait pin all sit outside this block.

Top module: `bus_wait_inserter`

## Requirements
- R1: The wait field of area a is bits [2a+1:2a] of the 16-bit word {high register, low register}. Writing with `wr_sel`=1 addresses the high register (areas 7..4), and `wr_sel`=0 addresses the low register (areas 3..0). Within each pair, the upper bit is the more significant.
- R2: A field value n (00=0, 01=1, 10=2, 11=3) makes `wait_o` high for exactly n cycles after the clock edge that samples `acc_start`. `ready_o` is high for exactly one cycle after those n cycles.
- R3: Zero waits are used when `acc_ext` is 0, or when `ast_en[area]` is 0, whatever the field holds. In that case `ready_o` is high in the cycle right after the start edge.
- R4: While `rst_n` is low, both registers read 0xFF, and `wait_o` and `ready_o` are low.
- R5: While `hw_stby` is high, both registers load 0xFF and register writes have no effect.
- R6: A low `mrst_n` ends the access in progress, so `wait_o` and `ready_o` go low, and it leaves both registers unchanged.
- R7: While `sw_stby` is high, no access starts, any running access is dropped, and both registers keep their contents.
- R8: A register write takes effect from the next access that starts. An access already counting keeps the wait count it loaded.
- R9: `rd_data` shows the full 8-bit contents of the register chosen by `rd_sel`, with no side effects. A write replaces all eight bits of the addressed register.
- R10: An `acc_start` pulse that arrives while an access is still running (waiting or ready) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, active low; clears the counter only |
| hw_stby | input | 1 | Hardware standby; forces the registers to 0xFF |
| sw_stby | input | 1 | Software standby; idles the counter, keeps the registers |
| acc_start | input | 1 | Bus access begins this cycle |
| acc_area | input | 3 | Area number of the access |
| acc_ext | input | 1 | 1 = external target, 0 = on-chip target |
| ast_en | input | 8 | Per-area three-state-access enable bits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 = high register, 0 = low register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 1 = high register, 0 = low register |
| rd_data | output | 8 | Contents of the selected register |
| wait_o | output | 1 | Access is being stretched |
| ready_o | output | 1 | One-cycle access-complete strobe |

## Verification
Some properties are checked by assertions on every cycle:
- `ready_o` lasts exactly one cycle and never overlaps `wait_o`.
- The counter steps down by one during each wait cycle.
- An internal access goes straight to ready.
- Hardware standby leaves the registers at all ones.
- Without a write or standby, the registers hold their value.

Other behaviour can only be shown by the bench's scenarios: the exact wait count for each field and area, the order of the fields within the two registers, a write landing in the middle of an access, and start pulses that overlap a running access. The bench also checks that manual reset and software standby leave the register contents unchanged.

// File: rtl/bwi_pkg.sv
// Package: default geometry shared by the wait-state inserter modules.
// Assumes register width is a multiple of the field width.
package bwi_pkg;
    localparam int unsigned DEF_AREAS   = 8;
    localparam int unsigned DEF_FIELD_W = 2;
    localparam int unsigned DEF_REG_W   = 8;
endpackage

// File: rtl/bwi_regs.sv
// Module: bwi_regs
// Holds the wait-control registers and presents them as one flat word
// (register 0 in the low bits). Assumes a synchronous active-low reset.
// Hardware standby forces all ones; nothing else but a write changes them.
module bwi_regs #(
    parameter int unsigned NREGS = 2,
    parameter int unsigned REG_W = 8,
    parameter int unsigned SEL_W = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_stby,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [REG_W-1:0]       rd_data,
    output logic [NREGS*REG_W-1:0] regs_flat
);

    genvar gi;
    generate
        for (gi = 0; gi < NREGS; gi++) begin : g_reg
            // Purpose: one register, preset by reset or hardware standby, else loaded by write.
            always_ff @(posedge clk) begin
                if (!rst_n || hw_stby)
                    regs_flat[gi*REG_W +: REG_W] <= '1;
                else if (wr_en && (wr_sel == SEL_W'(gi)))
                    regs_flat[gi*REG_W +: REG_W] <= wr_data;
            end
        end
    endgenerate

    // Purpose: side-effect-free readback mux.
    assign rd_data = regs_flat[rd_sel*REG_W +: REG_W];

    AST_STBY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (regs_flat == '1)); // R5
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hw_stby) |=> $stable(regs_flat)); // R6

endmodule

// File: rtl/bwi_sel.sv
// Module: bwi_sel
// Picks the wait count for the current access from the flat field word.
// Assumes AREAS is a power of two, so every area code is valid.
// Returns zero for on-chip targets or areas with three-state access off.
module bwi_sel #(
    parameter int unsigned AREAS   = 8,
    parameter int unsigned FIELD_W = 2,
    parameter int unsigned AREA_W  = 3
) (
    input  logic [AREAS*FIELD_W-1:0] fields,
    input  logic [AREA_W-1:0]        area,
    input  logic                     ext,
    input  logic [AREAS-1:0]         ast_en,
    output logic [FIELD_W-1:0]       waits
);

    // Purpose: gate the per-area field by target type and enable bit.
    always_comb begin
        if (ext && ast_en[area])
            waits = fields[area*FIELD_W +: FIELD_W];
        else
            waits = '0;
    end

endmodule

// File: rtl/bwi_counter.sv
// Module: bwi_counter
// Down-counter that stretches one access: loads the wait count at the start,
// shows wait for that many cycles, then gives ready for one cycle.
// Assumes starts during a running access are to be ignored.
module bwi_counter #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst_n,
    input  logic             sw_stby,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             wait_o,
    output logic             ready_o
);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Purpose: track the access, counting waits down to the ready cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !mrst_n || sw_stby) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= load_val;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            active <= 1'b0;
        end
    end

    // Purpose: decode the handshake outputs from the counter state.
    assign wait_o  = active && (cnt != '0);
    assign ready_o = active && (cnt == '0);

    AST_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n || sw_stby)
        wait_o |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n || sw_stby)
        (start && !wait_o && !ready_o) |=> (wait_o || ready_o)); // R10
    always_comb begin
        AST_WAIT_EXCL: assert (!(wait_o && ready_o)); // R2
    end

endmodule

// File: rtl/bus_wait_inserter.sv
// Module: bus_wait_inserter (top)
// Adds programmable wait states per external area to each bus access.
// Assumes acc_start is a one-cycle strobe from the bus sequencer, and that
// area, target and enable inputs are valid in that cycle.
module bus_wait_inserter #(
    parameter int unsigned AREAS   = bwi_pkg::DEF_AREAS,
    parameter int unsigned FIELD_W = bwi_pkg::DEF_FIELD_W,
    parameter int unsigned REG_W   = bwi_pkg::DEF_REG_W,
    localparam int unsigned NREGS  = AREAS * FIELD_W / REG_W,
    localparam int unsigned SEL_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int unsigned AREA_W = $clog2(AREAS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              acc_start,
    input  logic [AREA_W-1:0] acc_area,
    input  logic              acc_ext,
    input  logic [AREAS-1:0]  ast_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              wait_o,
    output logic              ready_o
);

    logic [NREGS*REG_W-1:0] regs_flat;
    logic [FIELD_W-1:0]     sel_waits;

    bwi_regs #(.NREGS(NREGS), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .regs_flat(regs_flat)
    );

    bwi_sel #(.AREAS(AREAS), .FIELD_W(FIELD_W), .AREA_W(AREA_W)) u_sel (
        .fields(regs_flat), .area(acc_area), .ext(acc_ext),
        .ast_en(ast_en), .waits(sel_waits)
    );

    bwi_counter #(.CNT_W(FIELD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .sw_stby(sw_stby),
        .start(acc_start), .load_val(sel_waits),
        .wait_o(wait_o), .ready_o(ready_o)
    );

    AST_NO_WAIT_INT: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n || sw_stby)
        (acc_start && !acc_ext && !wait_o && !ready_o) |=> ready_o); // R3
    AST_SW_STBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stby |=> (!wait_o && !ready_o)); // R7

endmodule

// File: tb/bus_wait_inserter_tb_top.sv
module bus_wait_inserter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, mrst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0;
    logic       acc_start = 1'b0, acc_ext = 1'b0, wr_en = 1'b0;
    logic [2:0] acc_area = '0;
    logic [7:0] ast_en = '0, wr_data = '0, rd_data;
    logic       wr_sel = 1'b0, rd_sel = 1'b0, wait_o, ready_o;

    int total = 0, bad = 0;
    logic [7:0] m_hi = 8'hFF, m_lo = 8'hFF;

    always #10 clk = ~clk;

    bus_wait_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .acc_start(acc_start), .acc_area(acc_area),
        .acc_ext(acc_ext), .ast_en(ast_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .wait_o(wait_o), .ready_o(ready_o)
    );

    function automatic int exp_waits(input logic [2:0] a, input logic e, input logic [7:0] en);
        logic [15:0] w;
        w = {m_hi, m_lo};
        if (!e || !en[a]) return 0;
        return int'(w[a*2 +: 2]);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic write_reg(input logic s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!hw_stby) begin
            if (s) m_hi = d; else m_lo = d;
        end
    endtask

    task automatic read_chk(input string tag);
        rd_sel = 1'b0; #1; check(tag, int'(rd_data), int'(m_lo));
        rd_sel = 1'b1; #1; check(tag, int'(rd_data), int'(m_hi));
    endtask

    task automatic run_access(input logic [2:0] a, input logic e, input logic [7:0] en, input string tag);
        int k;
        int ew;
        ew = exp_waits(a, e, en);
        @(negedge clk);
        acc_area = a; acc_ext = e; ast_en = en; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        k = 0;
        while (wait_o && k < 8) begin k++; @(negedge clk); end
        check(tag, k, ew);
        check(tag, int'(ready_o), 1);
        @(negedge clk);
        check(tag, int'(ready_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=timeout exp=done");
        finish_run();
    end

    initial begin
        int k;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 wait", int'(wait_o), 0);
        check("R4 ready", int'(ready_o), 0);
        read_chk("R4 regs");
        rst_n = 1'b1;
        // R2: default three waits
        run_access(3'd5, 1'b1, 8'hFF, "R2 default");
        // R1/R2: each area, each code, directed
        for (int a = 0; a < 8; a++) begin
            write_reg(1'b1, 8'h1B); // areas 7..4 = 0,1,2,3
            write_reg(1'b0, 8'hE4); // areas 3..0 = 3,2,1,0
            run_access(a[2:0], 1'b1, 8'hFF, "R1 field map");
        end
        // R3: internal target or disabled area
        run_access(3'd3, 1'b0, 8'hFF, "R3 internal");
        run_access(3'd3, 1'b1, 8'hF7, "R3 ast off");
        // R9: readback and full-byte write
        write_reg(1'b0, 8'h5A); write_reg(1'b1, 8'hC3);
        read_chk("R9 read");
        read_chk("R9 reread");
        // R8: write during access keeps loaded count
        write_reg(1'b0, 8'h0C); // area1 = 3
        @(negedge clk);
        acc_area = 3'd1; acc_ext = 1'b1; ast_en = 8'hFF; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
        k = 0;
        while (wait_o && k < 8) begin k++; @(negedge clk); wr_en = 1'b0; end
        m_lo = 8'h00;
        check("R8 in-flight", k, 3);
        check("R8 ready", int'(ready_o), 1);
        @(negedge clk);
        run_access(3'd1, 1'b1, 8'hFF, "R8 next access");
        // R10: start during running access ignored
        write_reg(1'b1, 8'h30); // area6 = 3
        @(negedge clk);
        acc_area = 3'd6; acc_ext = 1'b1; acc_start = 1'b1;
        @(negedge clk);
        acc_area = 3'd0; acc_ext = 1'b0; // keep start high: ignored
        k = 0;
        while (wait_o && k < 8) begin k++; @(negedge clk); acc_start = 1'b0; end
        check("R10 overlap", k, 3);
        check("R10 ready", int'(ready_o), 1);
        acc_start = 1'b0;
        @(negedge clk);
        // R6: manual reset mid access
        @(negedge clk);
        acc_area = 3'd6; acc_ext = 1'b1; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0; mrst_n = 1'b0;
        @(negedge clk);
        check("R6 wait", int'(wait_o), 0);
        check("R6 ready", int'(ready_o), 0);
        mrst_n = 1'b1;
        read_chk("R6 regs kept");
        // R7: software standby
        sw_stby = 1'b1;
        @(negedge clk);
        acc_area = 3'd6; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        check("R7 no start wait", int'(wait_o), 0);
        check("R7 no start ready", int'(ready_o), 0);
        sw_stby = 1'b0;
        read_chk("R7 regs kept");
        // R5: hardware standby presets and blocks writes
        hw_stby = 1'b1;
        write_reg(1'b0, 8'h11);
        m_hi = 8'hFF; m_lo = 8'hFF;
        read_chk("R5 ones");
        hw_stby = 1'b0;
        @(negedge clk);
        // random mix
        for (int i = 0; i < 60; i++) begin
            if ($urandom % 2 == 0) write_reg(1'($urandom), 8'($urandom));
            run_access(3'($urandom), 1'($urandom % 4 != 0), 8'($urandom), "R2 random");
        end
        read_chk("R9 final");
        finish_run();
    end

endmodule